// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and an incoming carry with no clock. It returns the sum and the outgoing carry. The operand width is split into equal slices. Inside a slice, every internal carry is a flat sum of products of the bit generate and propagate terms and the slice carry-in, so no carry ripples from bit to bit. Each slice also reports a group propagate and a group generate. A second lookahead level turns those group pairs and the main carry-in into the carry for every slice and the final carry-out. So no carry ripples from slice to slice either.

The second level also reports a section propagate and a section generate for the whole width. A wider adder can therefore use this block as one slice of a further lookahead level. The default build is 16 bits, made of four 4-bit slices. The bit propagate term can be built as inclusive OR or as exclusive OR. Both give the same sum and carries. The only visible difference is the section propagate output.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^16 for every input combination (default parameters).
- R2: `cout_o` equals bit 16 of the 17-bit unsigned value `a_i` + `b_i` + `cin_i`.
- R3: A carry entering at bit 0 reaches every higher bit and `cout_o` in the same evaluation when all operand bits propagate. For example, 0xFFFF + 0x0000 + 1 gives sum 0x0000 and carry-out 1, and 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF and carry-out 1.
- R4: `sect_g_o` is 1 exactly when `a_i` + `b_i`, with the carry-in taken as 0, exceeds 0xFFFF.
- R5: With the default inclusive-OR propagate, `sect_p_o` is 1 exactly when `a_i` | `b_i` is all ones. With the exclusive-OR propagate, it is 1 exactly when `a_i` ^ `b_i` is all ones.
- R6: `cout_o` equals `sect_g_o` OR (`sect_p_o` AND `cin_i`).
- R7: A carry produced at the top bit of slice k (bits 4k+3..4k) enters slice k+1. For example, 0x000F + 0x0001 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.
- R8: All outputs depend only on the present inputs. No state is held, and a new operand pair is reflected without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| sect_p_o | output | 1 | Section propagate over the full width |
| sect_g_o | output | 1 | Section generate over the full width |

## Verification
Every result of this block is due in the same cycle as its operands, with no register anywhere on the path. The bench therefore applies each operand pair just after a rising clock edge. On the following falling edge it compares sum, carry-out, section propagate and section generate against integer arithmetic. Since no value carries over from one vector to the next, the behavioural model in the bench needs no queue. The bound checker compares each slice's carry against its group signals at every input change.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // Choice of bit-level propagate term used by every slice.
   typedef enum int unsigned {
      PG_INCLUSIVE = 0,
      PG_EXCLUSIVE = 1
   } pg_kind_e;

   // Upper bounds keep the flat sum-of-products terms bounded in size.
   localparam int unsigned MAX_SLICE_W    = 8;
   localparam int unsigned MAX_NUM_SLICES = 8;

endpackage

// File: rtl/cla_pg_bit.sv
module cla_pg_bit #(
   parameter cla_pkg::pg_kind_e PG_KIND = cla_pkg::PG_INCLUSIVE
) (
   input  logic x_i,
   input  logic y_i,
   output logic g_o,
   output logic p_o
);

   assign g_o = x_i & y_i;

   generate
      if (PG_KIND == cla_pkg::PG_INCLUSIVE) begin : g_or_prop
         assign p_o = x_i | y_i;
      end else begin : g_xor_prop
         assign p_o = x_i ^ y_i;
      end
   endgenerate

endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
   parameter int unsigned        SLICE_W = 4,
   parameter cla_pkg::pg_kind_e  PG_KIND = cla_pkg::PG_INCLUSIVE
) (
   input  logic [SLICE_W-1:0] x_i,
   input  logic [SLICE_W-1:0] y_i,
   input  logic               cin_i,
   output logic [SLICE_W-1:0] s_o,
   output logic               grp_p_o,
   output logic               grp_g_o
);

   logic [SLICE_W-1:0] g_bit;
   logic [SLICE_W-1:0] p_bit;
   logic [SLICE_W-1:0] c_bit;   // carry into each bit, c_bit[0] is cin_i

   generate
      for (genvar b = 0; b < SLICE_W; b++) begin : g_bit_pg
         cla_pg_bit #(.PG_KIND(PG_KIND)) i_pg (
            .x_i (x_i[b]),
            .y_i (y_i[b]),
            .g_o (g_bit[b]),
            .p_o (p_bit[b])
         );
      end
   endgenerate

   // Each internal carry as a flat OR of AND terms over g/p and cin.
   always_comb begin
      c_bit[0] = cin_i;
      for (int j = 1; j < SLICE_W; j++) begin
         logic acc;
         logic term;
         acc = 1'b0;
         for (int m = 0; m < j; m++) begin
            term = g_bit[m];
            for (int q = m + 1; q < j; q++) begin
               term = term & p_bit[q];
            end
            acc = acc | term;
         end
         term = cin_i;
         for (int q = 0; q < j; q++) begin
            term = term & p_bit[q];
         end
         c_bit[j] = acc | term;
      end
   end

   // Group generate: carry out of the slice with a zero carry-in.
   always_comb begin
      logic term;
      grp_g_o = 1'b0;
      for (int m = 0; m < SLICE_W; m++) begin
         term = g_bit[m];
         for (int q = m + 1; q < SLICE_W; q++) begin
            term = term & p_bit[q];
         end
         grp_g_o = grp_g_o | term;
      end
   end

   assign grp_p_o = &p_bit;
   assign s_o     = x_i ^ y_i ^ c_bit;

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
   parameter int unsigned NUM_SLICES = 4
) (
   input  logic [NUM_SLICES-1:0] grp_p_i,
   input  logic [NUM_SLICES-1:0] grp_g_i,
   input  logic                  cin_i,
   output logic [NUM_SLICES:1]   carry_o,   // carry_o[k] enters slice k; top one leaves
   output logic                  sect_p_o,
   output logic                  sect_g_o
);

   always_comb begin
      for (int k = 1; k <= NUM_SLICES; k++) begin
         logic acc;
         logic term;
         acc = 1'b0;
         for (int m = 0; m < k; m++) begin
            term = grp_g_i[m];
            for (int q = m + 1; q < k; q++) begin
               term = term & grp_p_i[q];
            end
            acc = acc | term;
         end
         term = cin_i;
         for (int q = 0; q < k; q++) begin
            term = term & grp_p_i[q];
         end
         carry_o[k] = acc | term;
      end
   end

   always_comb begin
      logic term;
      sect_g_o = 1'b0;
      for (int m = 0; m < NUM_SLICES; m++) begin
         term = grp_g_i[m];
         for (int q = m + 1; q < NUM_SLICES; q++) begin
            term = term & grp_p_i[q];
         end
         sect_g_o = sect_g_o | term;
      end
   end

   assign sect_p_o = &grp_p_i;

endmodule

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder #(
   parameter int unsigned        SLICE_W    = 4,
   parameter int unsigned        NUM_SLICES = 4,
   parameter cla_pkg::pg_kind_e  PG_KIND    = cla_pkg::PG_INCLUSIVE,
   localparam int unsigned       WIDTH      = SLICE_W * NUM_SLICES
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             sect_p_o,
   output logic             sect_g_o
);

   generate
      if (SLICE_W < 1 || SLICE_W > cla_pkg::MAX_SLICE_W) begin : g_bad_slice_w
         $error("cla_two_level_adder: SLICE_W out of range");
      end
      if (NUM_SLICES < 1 || NUM_SLICES > cla_pkg::MAX_NUM_SLICES) begin : g_bad_num
         $error("cla_two_level_adder: NUM_SLICES out of range");
      end
   endgenerate

   logic [NUM_SLICES-1:0] grp_p;
   logic [NUM_SLICES-1:0] grp_g;
   logic [NUM_SLICES:1]   la_carry;
   logic [NUM_SLICES-1:0] slice_cin;

   generate
      for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
         if (k == 0) begin : g_first
            assign slice_cin[k] = cin_i;
         end else begin : g_rest
            assign slice_cin[k] = la_carry[k];
         end

         cla_slice #(
            .SLICE_W (SLICE_W),
            .PG_KIND (PG_KIND)
         ) i_slice (
            .x_i     (a_i[k*SLICE_W +: SLICE_W]),
            .y_i     (b_i[k*SLICE_W +: SLICE_W]),
            .cin_i   (slice_cin[k]),
            .s_o     (sum_o[k*SLICE_W +: SLICE_W]),
            .grp_p_o (grp_p[k]),
            .grp_g_o (grp_g[k])
         );
      end
   endgenerate

   cla_lookahead #(.NUM_SLICES(NUM_SLICES)) i_lookahead (
      .grp_p_i  (grp_p),
      .grp_g_i  (grp_g),
      .cin_i    (cin_i),
      .carry_o  (la_carry),
      .sect_p_o (sect_p_o),
      .sect_g_o (sect_g_o)
   );

   assign cout_o = la_carry[NUM_SLICES];

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
   parameter int unsigned        SLICE_W    = 4,
   parameter int unsigned        NUM_SLICES = 4,
   parameter cla_pkg::pg_kind_e  PG_KIND    = cla_pkg::PG_INCLUSIVE,
   localparam int unsigned       WIDTH      = SLICE_W * NUM_SLICES
) (
   input logic [WIDTH-1:0]      a_i,
   input logic [WIDTH-1:0]      b_i,
   input logic                  cin_i,
   input logic [WIDTH-1:0]      sum_o,
   input logic                  cout_o,
   input logic                  sect_p_o,
   input logic                  sect_g_o,
   input logic [NUM_SLICES-1:0] grp_p,
   input logic [NUM_SLICES-1:0] grp_g,
   input logic [NUM_SLICES-1:0] slice_cin
);

   logic [WIDTH:0] ref_total;
   logic [WIDTH:0] ref_nocin;

   always_comb begin
      ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
      ref_nocin = {1'b0, a_i} + {1'b0, b_i};

      // R1 and R2: the sum and carry-out match the arithmetic total.
      assert_sum_R1: assert ({cout_o, sum_o} == ref_total);

      // R4: the section generate matches the overflow with a zero carry-in.
      assert_sect_gen_R4: assert (sect_g_o == ref_nocin[WIDTH]);

      // R5: the section propagate matches the propagate kind over the operands.
      if (PG_KIND == cla_pkg::PG_INCLUSIVE) begin
         assert_sect_prop_R5: assert (sect_p_o == &(a_i | b_i));
      end else begin
         assert_sect_propx_R5: assert (sect_p_o == &(a_i ^ b_i));
      end

      // R6: the carry-out follows the section generate/propagate pair.
      assert_cout_gp_R6: assert (cout_o == (sect_g_o | (sect_p_o & cin_i)));

      // R7: the carry into the next slice follows this slice's group pair.
      for (int k = 0; k + 1 < NUM_SLICES; k++) begin
         assert_slice_carry_R7: assert (slice_cin[k+1] == (grp_g[k] | (grp_p[k] & slice_cin[k])));
      end
   end

endmodule

bind cla_two_level_adder cla_adder_chk #(
   .SLICE_W    (SLICE_W),
   .NUM_SLICES (NUM_SLICES),
   .PG_KIND    (PG_KIND)
) i_cla_adder_chk (
   .a_i       (a_i),
   .b_i       (b_i),
   .cin_i     (cin_i),
   .sum_o     (sum_o),
   .cout_o    (cout_o),
   .sect_p_o  (sect_p_o),
   .sect_g_o  (sect_g_o),
   .grp_p     (grp_p),
   .grp_g     (grp_g),
   .slice_cin (slice_cin)
);

// File: tb/test_cla_two_level_adder.sv
module test_cla_two_level_adder;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic         cin;
   logic [W-1:0] sum;
   logic         cout, sp, sg;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   cla_two_level_adder i_cla_two_level_adder (
      .a_i      (a),
      .b_i      (b),
      .cin_i    (cin),
      .sum_o    (sum),
      .cout_o   (cout),
      .sect_p_o (sp),
      .sect_g_o (sg)
   );

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b (a=%h b=%h cin=%0b)", req, what, act, exp, a, b, cin);
      end
   endtask

   task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s sum: actual %h expected %h (a=%h b=%h cin=%0b)", req, act, exp, a, b, cin);
      end
   endtask

   // Drive just after a rising edge, check at the next falling edge (same cycle).
   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv, input string req);
      int unsigned tot;
      int unsigned nocin;
      @(posedge clk);
      #0.5;
      a = av; b = bv; cin = cv;
      @(negedge clk);
      tot   = int'(av) + int'(bv) + int'(cv);
      nocin = int'(av) + int'(bv);
      check_vec({req, "/R1"}, sum, tot[W-1:0]);
      check_bit({req, "/R2"}, "cout", cout, tot[W]);
      check_bit({req, "/R4"}, "sect_g", sg, nocin[W]);
      check_bit({req, "/R5"}, "sect_p", sp, &(av | bv));
      check_bit({req, "/R6"}, "cout_vs_gp", cout, sg | (sp & cv));
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8: idle inputs give zero outputs, nothing held from before.
      check_vec("R8", sum, '0);
      check_bit("R8", "cout", cout, 1'b0);

      apply(16'h0000, 16'h0000, 1'b1, "R1");
      apply(16'hFFFF, 16'h0000, 1'b1, "R3");
      apply(16'hFFFF, 16'hFFFF, 1'b1, "R3");
      apply(16'hFFFF, 16'hFFFF, 1'b0, "R2");
      apply(16'h8000, 16'h8000, 1'b0, "R4");
      apply(16'h5555, 16'hAAAA, 1'b0, "R5");
      apply(16'h5555, 16'hAAAA, 1'b1, "R6");
      apply(16'h000F, 16'h0001, 1'b0, "R7");
      apply(16'h00FF, 16'h0001, 1'b0, "R7");
      apply(16'h0FFF, 16'h0001, 1'b0, "R7");
      apply(16'h0FF0, 16'h000F, 1'b1, "R7");
      apply(16'hF000, 16'h1000, 1'b0, "R2");
      // R8: back-to-back vectors, each judged only on its own inputs.
      for (int i = 0; i < 300; i++) begin
         apply(W'($urandom), W'($urandom), 1'($urandom), "R8");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule